// File: doc/BRIEF.md
# UART Transmit Byte Queue with Watermark Flag

This block is the transmit-side byte queue of a serial port. Software pushes characters by writing a data register. The character serializer pulls them one at a time over a valid/ready handshake. The queue holds up to `DEPTH` bytes and keeps an occupancy count. Status outputs report full and empty. Two single-cycle event pulses feed an interrupt collector: one when the fill level reaches a programmable threshold, and one when the queue runs dry.

A queue-control register selects the threshold and offers a self-clearing flush of the transmit queue. The same register also holds receive-side settings that are passed through to the receive path: a receive clear pulse and a 3-bit receive threshold code. A read-only queue-status register reports the transmit fill level next to a receive fill level supplied from outside. The serializer and the interrupt register are outside this block. Draining happens only while the external transmit-enable input is high.

Top module: `utx_fifo_top`

## Requirements
- R1: After reset the level is 0, `tx_empty` is 1, `tx_full`, `tx_wm`, `pop_valid` and both pulses are 0, and registers 0x20 and 0x24 read back as 0.
- R2: A write to offset 0x1C pushes bits 7:0 of `wr_data`. Upper bits are ignored. Bytes leave on `pop_data` in the order they were written, one per cycle in which `pop_valid` and `pop_ready` are both high.
- R3: A write to 0x1C while the level equals `DEPTH` (32) is discarded. The level stays 32 and the stored bytes are unchanged.
- R4: `tx_full` is high exactly when the level is 32, and it drops in the cycle after the first byte drains from a full queue.
- R5: `tx_empty` clears on the first accepted push. When the level returns to 0, `tx_empty` sets and `empty_set` pulses high for one cycle.
- R6: An accepted push that leaves the level at or above the threshold sets `tx_wm` and pulses `wm_set` for one cycle.
- R7: `tx_wm` stays high while drains keep the level at or above the threshold. It clears on the drain that takes the level below the threshold.
- R8: The threshold field is bits 6:5 of register 0x20. Codes 0, 1, 2 and 3 select 1, 4, 8 and 16 entries.
- R9: Writing 0x20 with bit 1 set empties the transmit queue in the next cycle. It clears `tx_wm`, and it pulses `empty_set` if the queue held data. Bit 1 reads back as 0.
- R10: Writing 0x20 with bit 0 set gives a one-cycle `rx_clr` pulse. Bits 4:2 are stored, driven on `rx_ilvl`, and read back. Bit 0 reads back as 0.
- R11: Register 0x24 reads the transmit level in bits 5:0 and `rx_level` in bits 21:16. Writes to it have no effect.
- R12: `pop_valid` is high only while `tx_en` is high and the queue is non-empty. With `tx_en` low the level never decreases, except by a flush.
- R13: An accepted push and a drain in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| tx_en | input | 1 | Transmit enable; gates draining |
| pop_ready | input | 1 | Serializer takes the head byte |
| pop_valid | output | 1 | Head byte available to the serializer |
| pop_data | output | 8 | Head byte |
| rx_level | input | 6 | Receive fill level, reported in 0x24 |
| rx_clr | output | 1 | One-cycle receive clear pulse |
| rx_ilvl | output | 3 | Stored receive threshold code |
| tx_level | output | 6 | Transmit fill level |
| tx_full | output | 1 | Queue holds DEPTH bytes |
| tx_empty | output | 1 | Queue holds no bytes |
| tx_wm | output | 1 | Watermark condition |
| wm_set | output | 1 | One-cycle watermark event |
| empty_set | output | 1 | One-cycle went-empty event |

## Verification
The bench fills the queue to 32 entries and writes once more. A design that wraps its pointer or level would then corrupt the oldest byte, or report 33 or 0. It walks all four threshold codes, both one entry short of the threshold and exactly on it. This exposes an off-by-one compare or a swapped decode, and draining back across the threshold catches a flag that clears too early or never. It pushes and drains in the same cycle, which catches a level update that favours one side. It also flushes a loaded queue, and it holds `tx_en` low over data, which reveals a design that drains regardless of the enable.

// File: rtl/utx_pkg.sv
// Shared constants, control-field layout and threshold decode for the
// transmit byte queue. Assumes 32-bit registers at byte offsets.
package utx_pkg;

    localparam logic [7:0] OFS_WDATA = 8'h1C;
    localparam logic [7:0] OFS_QCTRL = 8'h20;
    localparam logic [7:0] OFS_QSTAT = 8'h24;

    // queue-control field positions (decoded by neighbours, so fixed)
    localparam int BIT_RXCLR   = 0;
    localparam int BIT_TXFLUSH = 1;
    localparam int LSB_RXILVL  = 2;
    localparam int LSB_TXILVL  = 5;
    localparam int LSB_RXLVL   = 16;

    typedef struct packed {
        logic [2:0] rx_ilvl;
        logic [1:0] tx_ilvl;
    } qctrl_t;

    // threshold code to entry count: 0->1, 1->4, 2->8, 3->16
    function automatic logic [4:0] ilvl_to_count(input logic [1:0] code);
        logic [4:0] cnt;
        case (code)
            2'd0:    cnt = 5'd1;
            2'd1:    cnt = 5'd4;
            2'd2:    cnt = 5'd8;
            default: cnt = 5'd16;
        endcase
        return cnt;
    endfunction

endpackage

// File: rtl/utx_store.sv
// Circular byte storage with read/write pointers and an occupancy count.
// Assumes push is never asserted when full; flush overrides push and pop.
module utx_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head_data,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  level_nxt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // next-occupancy from the three level-changing events
    always_comb begin
        level_nxt = level;
        if (flush)
            level_nxt = '0;
        else if (push && !pop)
            level_nxt = level + LVL_W'(1);
        else if (pop && !push)
            level_nxt = level - LVL_W'(1);
    end

    // byte array write; storage needs no reset
    always_ff @(posedge clk) begin
        if (push && !flush)
            mem[wr_ptr] <= push_data;
    end

    // pointer and level registers
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
            level <= level_nxt;
        end
    end

    assign head_data = mem[rd_ptr];

endmodule

// File: rtl/utx_flags.sv
// Watermark flag and the two one-cycle event pulses.
// Assumes level_nxt is the occupancy after this cycle's push/pop/flush.
module utx_flags #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_nxt,
    input  logic [LVL_W-1:0] thresh,
    output logic             wm,
    output logic             wm_set,
    output logic             empty_set
);
    logic at_thr;

    // threshold compare on the occupancy being written this cycle
    always_comb at_thr = (level_nxt >= thresh);

    // watermark state and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm        <= 1'b0;
            wm_set    <= 1'b0;
            empty_set <= 1'b0;
        end else begin
            wm_set    <= push && at_thr;
            empty_set <= (level != '0) && (level_nxt == '0);
            if (push)
                wm <= at_thr;
            else if (pop || flush)
                wm <= wm && at_thr && (level_nxt != '0);
        end
    end

endmodule

// File: rtl/utx_regif.sv
// Register decode: data push, queue control and queue status readback.
// Assumes single-cycle writes and a combinational read port.
module utx_regif
    import utx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 32,
    parameter int DATA_W = 8,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              push_req,
    output logic [DATA_W-1:0] push_byte,
    output logic              flush_req,
    output logic              rx_clr,
    output qctrl_t            qctrl,
    output logic [REG_W-1:0]  rd_data
);
    logic wr_qctrl;

    // write decode
    always_comb begin
        push_req  = wr_en && (wr_addr == ADDR_W'(OFS_WDATA));
        wr_qctrl  = wr_en && (wr_addr == ADDR_W'(OFS_QCTRL));
        flush_req = wr_qctrl && wr_data[BIT_TXFLUSH];
        push_byte = wr_data[DATA_W-1:0];
    end

    // stored control fields and receive clear pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qctrl  <= '0;
            rx_clr <= 1'b0;
        end else begin
            rx_clr <= wr_qctrl && wr_data[BIT_RXCLR];
            if (wr_qctrl) begin
                qctrl.rx_ilvl <= wr_data[LSB_RXILVL +: 3];
                qctrl.tx_ilvl <= wr_data[LSB_TXILVL +: 2];
            end
        end
    end

    // read multiplexer; action bits read as zero
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_QCTRL)) begin
            rd_data[LSB_RXILVL +: 3] = qctrl.rx_ilvl;
            rd_data[LSB_TXILVL +: 2] = qctrl.tx_ilvl;
        end else if (rd_addr == ADDR_W'(OFS_QSTAT)) begin
            rd_data[LVL_W-1:0]          = tx_level;
            rd_data[LSB_RXLVL +: LVL_W] = rx_level;
        end
    end

endmodule

// File: rtl/utx_fifo_top.sv
// Transmit byte queue top: joins register decode, storage and flag logic,
// and gates pushes on full and drains on transmit enable.
// Assumes DEPTH >= 16 so every threshold code is reachable.
module utx_fifo_top
    import utx_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 8,
    parameter int REG_W  = 32,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              tx_en,
    input  logic              pop_ready,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              rx_clr,
    output logic [2:0]        rx_ilvl,
    output logic [LVL_W-1:0]  tx_level,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_wm,
    output logic              wm_set,
    output logic              empty_set
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic              push_req;
    logic [DATA_W-1:0] push_byte;
    logic              flush_req;
    qctrl_t            qctrl;
    logic              push;
    logic              pop;
    logic [LVL_W-1:0]  level_nxt;
    logic [LVL_W-1:0]  thresh;

    utx_regif #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W)
    ) i_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .push_req  (push_req),
        .push_byte (push_byte),
        .flush_req (flush_req),
        .rx_clr    (rx_clr),
        .qctrl     (qctrl),
        .rd_data   (rd_data)
    );

    // status from the registered level, and the handshake gating
    always_comb begin
        tx_full   = (tx_level == LVL_FULL);
        tx_empty  = (tx_level == '0);
        pop_valid = tx_en && !tx_empty;
        push      = push_req && !tx_full;
        pop       = pop_valid && pop_ready && !flush_req;
        thresh    = LVL_W'(ilvl_to_count(qctrl.tx_ilvl));
        rx_ilvl   = qctrl.rx_ilvl;
    end

    utx_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_byte),
        .pop       (pop),
        .flush     (flush_req),
        .head_data (pop_data),
        .level     (tx_level),
        .level_nxt (level_nxt)
    );

    utx_flags #(
        .LVL_W (LVL_W)
    ) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .flush     (flush_req),
        .level     (tx_level),
        .level_nxt (level_nxt),
        .thresh    (thresh),
        .wm        (tx_wm),
        .wm_set    (wm_set),
        .empty_set (empty_set)
    );

endmodule

// File: rtl/utx_fifo_chk.sv
// Protocol checks on the top-level ports of the transmit byte queue.
module utx_fifo_chk
    import utx_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 8,
    parameter int REG_W  = 32,
    parameter int LVL_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              tx_en,
    input logic              pop_ready,
    input logic              pop_valid,
    input logic [LVL_W-1:0]  tx_level,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              tx_wm,
    input logic              wm_set,
    input logic              empty_set
);
    logic wr_push;
    logic wr_flush;
    logic drain;

    always_comb begin
        wr_push  = wr_en && (wr_addr == ADDR_W'(OFS_WDATA));
        wr_flush = wr_en && (wr_addr == ADDR_W'(OFS_QCTRL)) && wr_data[BIT_TXFLUSH];
        drain    = pop_valid && pop_ready;
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && wr_push && !drain) |=> (tx_level == LVL_W'(DEPTH)));

    // R4
    full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && drain && !wr_flush) |=> !tx_full);

    // R5
    empty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_set |-> (tx_empty && !$past(tx_empty)));

    // R6
    wm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wm_set |-> tx_wm);

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flush |=> (tx_level == '0) && !tx_wm);

    // R12
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !wr_flush) |=> (tx_level >= $past(tx_level)));

    // R13
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_push && drain && !tx_full) |=> $stable(tx_level));

endmodule

bind utx_fifo_top utx_fifo_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .LVL_W  (LVL_W)
) i_utx_fifo_chk (.*);

// File: tb/test_utx_fifo_top.sv
// Directed bench for the transmit byte queue: one task per scenario.
module test_utx_fifo_top;

    localparam int DEPTH = 32;
    localparam int LVL_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [7:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              tx_en = 1'b0;
    logic              pop_ready = 1'b0;
    logic              pop_valid;
    logic [7:0]        pop_data;
    logic [LVL_W-1:0]  rx_level = '0;
    logic              rx_clr;
    logic [2:0]        rx_ilvl;
    logic [LVL_W-1:0]  tx_level;
    logic              tx_full;
    logic              tx_empty;
    logic              tx_wm;
    logic              wm_set;
    logic              empty_set;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    utx_fifo_top i_utx_fifo_top (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pop_one(input logic [7:0] exp, input string req);
        @(negedge clk);
        eq({req, " valid"}, {31'd0, pop_valid}, 32'd1);
        eq({req, " data"}, {24'd0, pop_data}, {24'd0, exp});
        pop_ready = 1'b1;
        @(negedge clk);
        pop_ready = 1'b0;
    endtask

    task automatic flush_q(input logic [1:0] code);
        reg_wr(8'h20, (32'(code) << 5) | 32'h2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        eq("R1 level", {26'd0, tx_level}, 32'd0);
        eq("R1 empty", {31'd0, tx_empty}, 32'd1);
        eq("R1 full/wm/valid", {28'd0, tx_full, tx_wm, pop_valid, wm_set}, 32'd0);
        reg_rd(8'h24, d); eq("R1 status reg", d, 32'd0);
        reg_rd(8'h20, d); eq("R1 ctrl reg", d, 32'd0);
    endtask

    task automatic t_order();
        tx_en = 1'b0;
        reg_wr(8'h1C, 32'hABCDEF11);
        eq("R5 empty cleared", {31'd0, tx_empty}, 32'd0);
        eq("R6 wm pulse thr1", {30'd0, wm_set, tx_wm}, 32'd3);
        reg_wr(8'h1C, 32'h00000022);
        reg_wr(8'h1C, 32'hFFFFFF33);
        eq("R2 level 3", {26'd0, tx_level}, 32'd3);
        repeat (4) @(negedge clk);
        eq("R12 no valid when disabled", {31'd0, pop_valid}, 32'd0);
        eq("R12 level held", {26'd0, tx_level}, 32'd3);
        tx_en = 1'b1;
        pop_one(8'h11, "R2 first");
        pop_one(8'h22, "R2 second");
        eq("R7 wm kept at 1", {31'd0, tx_wm}, 32'd1);
        pop_one(8'h33, "R2 third");
        eq("R5 empty pulse", {30'd0, empty_set, tx_empty}, 32'd3);
        eq("R7 wm cleared at 0", {31'd0, tx_wm}, 32'd0);
        @(negedge clk);
        eq("R5 pulse one cycle", {31'd0, empty_set}, 32'd0);
    endtask

    task automatic t_thresholds();
        for (int code = 0; code < 4; code++) begin
            int thr;
            thr = (code == 0) ? 1 : (2 << code);
            tx_en = 1'b1;
            flush_q(2'(code));
            for (int k = 0; k < thr - 1; k++) reg_wr(8'h1C, 32'(k));
            eq("R8 below threshold", {31'd0, tx_wm}, 32'd0);
            reg_wr(8'h1C, 32'(thr - 1));
            eq("R8 at threshold", {30'd0, tx_wm, wm_set}, 32'd3);
            reg_wr(8'h1C, 32'(thr));
            pop_one(8'd0, "R2 thr order");
            eq("R7 wm still at thr", {31'd0, tx_wm}, 32'd1);
            pop_one(8'd1, "R2 thr order");
            eq("R7 wm below thr", {31'd0, tx_wm}, 32'd0);
        end
        flush_q(2'd0);
    endtask

    task automatic t_full();
        tx_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) reg_wr(8'h1C, 32'(k + 1));
        eq("R4 full", {26'd0, tx_full, tx_level}, {26'd0, 1'b1, 6'd32});
        reg_wr(8'h1C, 32'hEE);
        eq("R3 dropped level", {26'd0, tx_level}, 32'd32);
        tx_en = 1'b1;
        pop_one(8'd1, "R3 head intact");
        eq("R4 full released", {31'd0, tx_full}, 32'd0);
        reg_wr(8'h1C, 32'h5A);
        for (int k = 2; k <= DEPTH; k++) pop_one(8'(k), "R3 order kept");
        pop_one(8'h5A, "R3 no stray byte");
        eq("R5 empty after full drain", {31'd0, tx_empty}, 32'd1);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        tx_en = 1'b0;
        for (int k = 0; k < 5; k++) reg_wr(8'h1C, 32'(k));
        flush_q(2'd1);
        eq("R9 flushed", {26'd0, tx_level}, 32'd0);
        eq("R9 empty pulse / wm", {29'd0, empty_set, tx_empty, tx_wm}, 32'd6);
        reg_rd(8'h20, d); eq("R9 readback", d, 32'h20);
        reg_wr(8'h1C, 32'h77);
        tx_en = 1'b1;
        pop_one(8'h77, "R9 fresh data after flush");
        flush_q(2'd0);
    endtask

    task automatic t_rx_ctrl();
        logic [31:0] d;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h20; wr_data = (32'd5 << 2) | 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        eq("R10 rx clear pulse", {31'd0, rx_clr}, 32'd1);
        eq("R10 rx ilvl", {29'd0, rx_ilvl}, 32'd5);
        reg_rd(8'h20, d); eq("R10 readback", d, 32'h14);
        @(negedge clk);
        eq("R10 pulse one cycle", {31'd0, rx_clr}, 32'd0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        tx_en = 1'b0;
        rx_level = 6'd7;
        reg_wr(8'h1C, 32'h1);
        reg_wr(8'h1C, 32'h2);
        reg_rd(8'h24, d); eq("R11 levels", d, (32'd7 << 16) | 32'd2);
        reg_wr(8'h24, 32'hFFFFFFFF);
        reg_rd(8'h24, d); eq("R11 write ignored", d, (32'd7 << 16) | 32'd2);
        flush_q(2'd0);
        rx_level = '0;
    endtask

    task automatic t_same_cycle();
        tx_en = 1'b1;
        reg_wr(8'h1C, 32'hA1);
        reg_wr(8'h1C, 32'hA2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h1C; wr_data = 32'hA3; pop_ready = 1'b1;
        eq("R13 head before", {24'd0, pop_data}, 32'hA1);
        @(negedge clk);
        wr_en = 1'b0; pop_ready = 1'b0;
        eq("R13 level unchanged", {26'd0, tx_level}, 32'd2);
        pop_one(8'hA2, "R13 order");
        pop_one(8'hA3, "R13 order");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_thresholds();
        t_full();
        t_flush();
        t_rx_ctrl();
        t_status();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule